// File: doc/BRIEF.md
# NAND Flash Command Front End

This block is the device-side front end of a NAND flash target. It watches the flash bus strobes: chip select, command latch, address latch, write enable and the 8-bit I/O lines. It captures each byte written on a rising write-enable edge. From those bytes it decodes the command set into single-cycle operation strobes. Each strobe carries an operation code, the assembled column and row address, and the page-register area that a read points at. The storage array, its timing and the data path to the page register belong to other blocks. This block only says which operation was requested and where it applies.

The block keeps a three-way read-area pointer: first half, second half or spare area. The second-half setting is used for one read and then falls back to the first half on its own. Sequences are checked: address bytes are counted per operation, and confirm bytes must arrive in the right context. Undefined command bytes raise an illegal flag. Commands that arrive while the array reports busy are turned away, except status and reset.

All bus inputs are sampled by the block clock, which must be fast enough to see every write-enable low and high phase. Every result (operation strobe or flag) is a one-clock pulse. It appears in the clock cycle after the clock edge at which the write-enable rising edge is first seen.

Top module: `nandCmdFrontEnd`

## Requirements
- R1: A byte is taken only when write enable is seen rising while chip select is low. The byte is a command when command latch is high and address latch is low. It is an address byte when address latch is high and command latch is low. Any other byte (chip select high, both latches high, or neither) causes no result pulse.
- R2: Every accepted byte produces at most one result pulse, lasting exactly one clock: opValid with opCode, illegalCmd, seqErr, or busyReject. After reset every output is low or zero. opCode values are: 1 read, 2 program, 3 dummy program, 4 copy-back, 5 dummy copy-back, 6 erase, 7 multi-plane erase, 8 status, 9 multi-plane status, 10 read ID, 11 reset.
- R3: Command 00h sets areaPtr to 0 (first half), 01h sets it to 1 (second half), 50h sets it to 2 (spare area), and FFh sets it back to 0. The value 3 never occurs.
- R4: A read issued while areaPtr is 1 reports opArea 1, and areaPtr is 0 from the following cycle on.
- R5: After 00h, 01h or 50h, the fourth address byte issues a read (opCode 1). opCol is address byte 0, opRow is {byte3[0], byte2, byte1}, and opArea is the pointer in use.
- R6: 80h, four address bytes, then 10h issues a program (opCode 2); 11h in place of 10h issues a dummy program (opCode 3). Column and row are formed as in R5.
- R7: After a completed read, 8Ah, four address bytes, then 10h issues a copy-back (opCode 4) with the new address; 11h issues a dummy copy-back (opCode 5).
- R8: 60h, three address bytes, then D0h issues an erase (opCode 6) with opCol 0 and opRow {byte2[0], byte1, byte0}. One or more repeats of 60h plus three address bytes before the D0h issue a multi-plane erase (opCode 7) holding the last row.
- R9: 70h issues status (8), 71h multi-plane status (9), 90h read ID (10), and FFh reset (11). Reset also drops any sequence in progress.
- R10: A command byte outside {00h,01h,50h,60h,70h,71h,80h,8Ah,90h,10h,11h,D0h,FFh} raises illegalCmd and drops any sequence in progress.
- R11: seqErr is raised, and no operation issued, in these cases: a confirm (10h, 11h, D0h) with the wrong address count or outside its sequence; 8Ah not directly after a completed read; an address byte beyond the expected count or outside an address phase; a repeated 60h after a short address phase.
- R12: While busyIn is high, only 70h, 71h and FFh are acted on. Every other command byte and every address byte raises busyReject and leaves the sequence state and the address count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSelN | input | 1 | Chip select, active low |
| cmdLatch | input | 1 | Command latch enable |
| addrLatch | input | 1 | Address latch enable |
| writeEnN | input | 1 | Write enable, byte taken on its rising edge |
| ioIn | input | 8 | Bus byte |
| busyIn | input | 1 | Array busy |
| opValid | output | 1 | Operation strobe |
| opCode | output | 4 | Operation code (R2) |
| opArea | output | 2 | Read area for the operation |
| opCol | output | 8 | Column address |
| opRow | output | 17 | Row address |
| areaPtr | output | 2 | Current read-area pointer |
| illegalCmd | output | 1 | Undefined command pulse |
| seqErr | output | 1 | Sequence error pulse |
| busyReject | output | 1 | Command refused while busy |

## Verification
A wrong sequence state shows at the ports on the next confirm or address byte, which then gives a misplaced seqErr or a wrong opCode one clock after the byte. A wrong address count or a wrong address byte order shows as a wrong opRow or opCol on the operation strobe that closes the sequence. A pointer that fails to fall back from the second half shows on areaPtr in the cycle after the read. A busy gate that leaks shows as an opValid or a later shifted address in place of busyReject. The bench sweeps all 256 command bytes in the idle state and under busy, and it runs every sequence type over several address patterns.

// File: rtl/nandFePkg.sv
package nandFePkg;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_READ       = 4'd1,
    OP_PROG       = 4'd2,
    OP_PROG_DUMMY = 4'd3,
    OP_CB         = 4'd4,
    OP_CB_DUMMY   = 4'd5,
    OP_ERASE      = 4'd6,
    OP_ERASE_MP   = 4'd7,
    OP_STATUS     = 4'd8,
    OP_STATUS_MP  = 4'd9,
    OP_ID         = 4'd10,
    OP_RESET      = 4'd11
  } opcode_t;

  typedef enum logic [1:0] {
    AREA_FIRST  = 2'd0,
    AREA_SECOND = 2'd1,
    AREA_SPARE  = 2'd2
  } area_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  clrAddr;
    logic  shiftAddr;
    logic  setPtr;
    area_t ptrVal;
    logic  latchOp;
    logic  eraseFmt;
    logic  readAccess;
  } ctlStrobe_t;

endpackage

// File: rtl/nandFeData.sv
module nandFeData
  import nandFePkg::*;
#(
  parameter int COL_W    = 8,
  parameter int ROW_W    = 17,
  parameter int ADDR_MAX = 4,
  parameter int CNT_W    = $clog2(ADDR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic             writeEnN,
  input  logic [7:0]       ioIn,
  input  ctlStrobe_t       ctl,
  output logic             byteStb,
  output logic             isCmd,
  output logic             isAddr,
  output logic [7:0]       byteVal,
  output logic [CNT_W-1:0] addrCnt,
  output logic [1:0]       areaPtr,
  output logic [1:0]       opArea,
  output logic [COL_W-1:0] opCol,
  output logic [ROW_W-1:0] opRow
);

  localparam int PACK_W = 8 * ADDR_MAX;

  logic                weQ;
  logic [7:0]          addrByte [ADDR_MAX];
  logic [7:0]          nextByte [ADDR_MAX];
  logic [PACK_W-1:0]   packedAddr;
  area_t               ptrQ;

  always_ff @(posedge clk) begin
    if (!rstN) weQ <= 1'b1;
    else       weQ <= writeEnN;
  end

  assign byteStb = !weQ && writeEnN && !chipSelN;
  assign isCmd   = cmdLatch && !addrLatch;
  assign isAddr  = addrLatch && !cmdLatch;
  assign byteVal = ioIn;

  // next address bytes including the one arriving now
  always_comb begin
    for (int i = 0; i < ADDR_MAX; i++) begin
      nextByte[i] = addrByte[i];
      if (ctl.shiftAddr && addrCnt == CNT_W'(i)) nextByte[i] = ioIn;
      packedAddr[8*i +: 8] = nextByte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      for (int i = 0; i < ADDR_MAX; i++) addrByte[i] <= '0;
    end else begin
      if (ctl.clrAddr)        addrCnt <= '0;
      else if (ctl.shiftAddr) addrCnt <= addrCnt + 1'b1;
      for (int i = 0; i < ADDR_MAX; i++) addrByte[i] <= nextByte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCol  <= '0;
      opRow  <= '0;
      opArea <= '0;
    end else if (ctl.latchOp) begin
      opArea <= ptrQ;
      if (ctl.eraseFmt) begin
        opCol <= '0;
        opRow <= ROW_W'(packedAddr);
      end else begin
        opCol <= COL_W'(packedAddr);
        opRow <= ROW_W'(packedAddr >> 8);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                      ptrQ <= AREA_FIRST;
    else if (ctl.setPtr)                            ptrQ <= ctl.ptrVal;
    else if (ctl.readAccess && ptrQ == AREA_SECOND) ptrQ <= AREA_FIRST;
  end

  assign areaPtr = ptrQ;

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    addrCnt <= CNT_W'(ADDR_MAX)); // R11
  AST_PTR_REVERT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readAccess && !ctl.setPtr && areaPtr == 2'd1) |=> areaPtr == 2'd0); // R4
  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    areaPtr != 2'd3); // R3

endmodule

// File: rtl/nandFeCtrl.sv
module nandFeCtrl
  import nandFePkg::*;
#(
  parameter int ADDR_MAX   = 4,
  parameter int ERASE_ADDR = 3,
  parameter int PLANE_MAX  = 4,
  parameter int CNT_W      = $clog2(ADDR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteStb,
  input  logic             isCmd,
  input  logic             isAddr,
  input  logic [7:0]       byteVal,
  input  logic [CNT_W-1:0] addrCnt,
  input  logic             busyIn,
  output ctlStrobe_t       ctl,
  output logic             opValid,
  output opcode_t          opCode,
  output logic             illegalCmd,
  output logic             seqErr,
  output logic             busyReject
);

  localparam int PLANE_W = $clog2(PLANE_MAX);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDADR, ST_RDDONE, ST_CBADR, ST_PGADR, ST_ERADR
  } state_t;

  state_t             state, nxtState;
  logic [PLANE_W-1:0] planeCnt, nxtPlane;
  logic               nValid, nIll, nSeq, nBusy;
  opcode_t            nCode;
  logic               fullAddr, eraseFull;

  assign fullAddr  = addrCnt == CNT_W'(ADDR_MAX);
  assign eraseFull = addrCnt == CNT_W'(ERASE_ADDR);

  always_comb begin
    nxtState = state;
    nxtPlane = planeCnt;
    nValid   = 1'b0;
    nCode    = OP_NONE;
    nIll     = 1'b0;
    nSeq     = 1'b0;
    nBusy    = 1'b0;
    ctl      = '0;
    if (byteStb && isCmd) begin
      if (busyIn && !(byteVal inside {8'h70, 8'h71, 8'hFF})) begin
        nBusy = 1'b1;
      end else begin
        case (byteVal)
          8'hFF: begin
            nValid = 1'b1; nCode = OP_RESET; nxtState = ST_IDLE;
            ctl.setPtr = 1'b1; ctl.ptrVal = AREA_FIRST; ctl.clrAddr = 1'b1;
          end
          8'h70: begin nValid = 1'b1; nCode = OP_STATUS; end
          8'h71: begin nValid = 1'b1; nCode = OP_STATUS_MP; end
          8'h90: begin nValid = 1'b1; nCode = OP_ID; nxtState = ST_IDLE; end
          8'h00, 8'h01, 8'h50: begin
            ctl.setPtr  = 1'b1;
            ctl.ptrVal  = (byteVal == 8'h00) ? AREA_FIRST :
                          (byteVal == 8'h01) ? AREA_SECOND : AREA_SPARE;
            ctl.clrAddr = 1'b1;
            nxtState    = ST_RDADR;
          end
          8'h80: begin ctl.clrAddr = 1'b1; nxtState = ST_PGADR; end
          8'h60: begin
            ctl.clrAddr = 1'b1;
            nxtState    = ST_ERADR;
            nxtPlane    = '0;
            if (state == ST_ERADR) begin
              if (eraseFull && planeCnt < PLANE_W'(PLANE_MAX - 1))
                nxtPlane = planeCnt + 1'b1;
              else
                nSeq = 1'b1;
            end
          end
          8'h8A: begin
            if (state == ST_RDDONE) begin
              ctl.clrAddr = 1'b1; nxtState = ST_CBADR;
            end else begin
              nSeq = 1'b1; nxtState = ST_IDLE;
            end
          end
          8'h10, 8'h11: begin
            nxtState = ST_IDLE;
            if ((state == ST_PGADR || state == ST_CBADR) && fullAddr) begin
              nValid = 1'b1; ctl.latchOp = 1'b1;
              if (state == ST_PGADR) nCode = (byteVal == 8'h10) ? OP_PROG : OP_PROG_DUMMY;
              else                   nCode = (byteVal == 8'h10) ? OP_CB : OP_CB_DUMMY;
            end else begin
              nSeq = 1'b1;
            end
          end
          8'hD0: begin
            nxtState = ST_IDLE;
            if (state == ST_ERADR && eraseFull) begin
              nValid = 1'b1; ctl.latchOp = 1'b1; ctl.eraseFmt = 1'b1;
              nCode  = (planeCnt != '0) ? OP_ERASE_MP : OP_ERASE;
            end else begin
              nSeq = 1'b1;
            end
          end
          default: begin nIll = 1'b1; nxtState = ST_IDLE; end
        endcase
      end
    end else if (byteStb && isAddr) begin
      if (busyIn) begin
        nBusy = 1'b1;
      end else begin
        case (state)
          ST_RDADR, ST_PGADR, ST_CBADR: begin
            if (!fullAddr) begin
              ctl.shiftAddr = 1'b1;
              if (state == ST_RDADR && addrCnt == CNT_W'(ADDR_MAX - 1)) begin
                nValid = 1'b1; nCode = OP_READ; ctl.latchOp = 1'b1;
                ctl.readAccess = 1'b1; nxtState = ST_RDDONE;
              end
            end else begin
              nSeq = 1'b1;
            end
          end
          ST_ERADR: begin
            if (!eraseFull) ctl.shiftAddr = 1'b1;
            else            nSeq = 1'b1;
          end
          default: nSeq = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      planeCnt   <= '0;
      opValid    <= 1'b0;
      opCode     <= OP_NONE;
      illegalCmd <= 1'b0;
      seqErr     <= 1'b0;
      busyReject <= 1'b0;
    end else begin
      state      <= nxtState;
      planeCnt   <= nxtPlane;
      opValid    <= nValid;
      opCode     <= nCode;
      illegalCmd <= nIll;
      seqErr     <= nSeq;
      busyReject <= nBusy;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opValid, illegalCmd, seqErr, busyReject})); // R2
  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (byteStb && busyIn) |=> (!opValid || opCode == OP_STATUS ||
                             opCode == OP_STATUS_MP || opCode == OP_RESET)); // R12
  AST_CONFIRM_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (byteStb && isCmd && !busyIn && byteVal == 8'h10 && !fullAddr) |=> !opValid); // R11

endmodule

// File: rtl/nandCmdFrontEnd.sv
module nandCmdFrontEnd
  import nandFePkg::*;
#(
  parameter int COL_W      = 8,
  parameter int ROW_W      = 17,
  parameter int ADDR_MAX   = 4,
  parameter int ERASE_ADDR = 3,
  parameter int PLANE_MAX  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic             writeEnN,
  input  logic [7:0]       ioIn,
  input  logic             busyIn,
  output logic             opValid,
  output logic [3:0]       opCode,
  output logic [1:0]       opArea,
  output logic [COL_W-1:0] opCol,
  output logic [ROW_W-1:0] opRow,
  output logic [1:0]       areaPtr,
  output logic             illegalCmd,
  output logic             seqErr,
  output logic             busyReject
);

  localparam int CNT_W = $clog2(ADDR_MAX + 1);

  ctlStrobe_t       ctl;
  logic             byteStb, isCmd, isAddr;
  logic [7:0]       byteVal;
  logic [CNT_W-1:0] addrCnt;
  opcode_t          opCodeE;

  nandFeData #(.COL_W(COL_W), .ROW_W(ROW_W), .ADDR_MAX(ADDR_MAX), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .cmdLatch(cmdLatch),
    .addrLatch(addrLatch), .writeEnN(writeEnN), .ioIn(ioIn), .ctl(ctl),
    .byteStb(byteStb), .isCmd(isCmd), .isAddr(isAddr), .byteVal(byteVal),
    .addrCnt(addrCnt), .areaPtr(areaPtr), .opArea(opArea), .opCol(opCol), .opRow(opRow)
  );

  nandFeCtrl #(.ADDR_MAX(ADDR_MAX), .ERASE_ADDR(ERASE_ADDR), .PLANE_MAX(PLANE_MAX),
               .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .byteStb(byteStb), .isCmd(isCmd), .isAddr(isAddr),
    .byteVal(byteVal), .addrCnt(addrCnt), .busyIn(busyIn), .ctl(ctl),
    .opValid(opValid), .opCode(opCodeE), .illegalCmd(illegalCmd),
    .seqErr(seqErr), .busyReject(busyReject)
  );

  assign opCode = opCodeE;

  AST_ERASE_COL: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 4'd6 || opCode == 4'd7)) |-> opCol == '0); // R8

endmodule

// File: tb/test_nandCmdFrontEnd.sv
module test_nandCmdFrontEnd;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipSelN = 1'b0, cmdLatch = 1'b0, addrLatch = 1'b0, writeEnN = 1'b1;
  logic [7:0]  ioIn = '0;
  logic        busyIn = 1'b0;
  logic        opValid, illegalCmd, seqErr, busyReject;
  logic [3:0]  opCode;
  logic [1:0]  opArea, areaPtr;
  logic [7:0]  opCol;
  logic [16:0] opRow;

  int errors = 0;
  int checks = 0;
  int lastEvt, lastCol, lastRow, lastArea;

  always #(CLK_PERIOD/2) clk = ~clk;

  nandCmdFrontEnd i_nandCmdFrontEnd (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .cmdLatch(cmdLatch),
    .addrLatch(addrLatch), .writeEnN(writeEnN), .ioIn(ioIn), .busyIn(busyIn),
    .opValid(opValid), .opCode(opCode), .opArea(opArea), .opCol(opCol),
    .opRow(opRow), .areaPtr(areaPtr), .illegalCmd(illegalCmd),
    .seqErr(seqErr), .busyReject(busyReject)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // event code: opCode, 12 illegal, 13 sequence error, 14 busy reject, 0 none
  task automatic sendByte(input logic cle, input logic ale, input logic [7:0] b);
    @(negedge clk);
    cmdLatch = cle; addrLatch = ale; ioIn = b; writeEnN = 1'b0;
    @(negedge clk);
    writeEnN = 1'b1;
    @(negedge clk);
    lastEvt  = opValid ? int'(opCode) : illegalCmd ? 12 : seqErr ? 13 : busyReject ? 14 : 0;
    lastCol  = int'(opCol);
    lastRow  = int'(opRow);
    lastArea = int'(opArea);
    cmdLatch = 1'b0; addrLatch = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    sendByte(1'b1, 1'b0, b);
  endtask

  task automatic adr(input logic [7:0] b);
    sendByte(1'b0, 1'b1, b);
  endtask

  function automatic int expIdle(input int b);
    case (b)
      'h70: return 8;
      'h71: return 9;
      'h90: return 10;
      'hFF: return 11;
      'h8A, 'h10, 'h11, 'hD0: return 13;
      'h00, 'h01, 'h50, 'h80, 'h60: return 0;
      default: return 12;
    endcase
  endfunction

  function automatic int rowOf(input int b1, input int b2, input int b3);
    return ((b3 & 1) << 16) | ((b2 & 255) << 8) | (b1 & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset outputs", int'({opValid, illegalCmd, seqErr, busyReject}), 0);
    chk("R2 reset opCode", int'(opCode), 0);
    chk("R3 reset pointer", int'(areaPtr), 0);

    // R1 capture qualifiers
    chipSelN = 1'b1; cmd(8'h70); chk("R1 chip select high", lastEvt, 0); chipSelN = 1'b0;
    sendByte(1'b1, 1'b1, 8'h70); chk("R1 both latches", lastEvt, 0);
    sendByte(1'b0, 1'b0, 8'h70); chk("R1 no latch", lastEvt, 0);
    cmd(8'h70); chk("R1 command taken", lastEvt, 8);

    // R9 R10 R11 idle sweep over every command byte
    for (int b = 0; b < 256; b++) begin
      cmd(8'(b));
      chk("R10 R9 R11 idle command", lastEvt, expIdle(b));
      cmd(8'hFF);
    end

    // R12 busy sweep
    busyIn = 1'b1;
    for (int b = 0; b < 256; b++) begin
      int e;
      e = (b == 'h70) ? 8 : (b == 'h71) ? 9 : (b == 'hFF) ? 11 : 14;
      cmd(8'(b));
      chk("R12 busy command", lastEvt, e);
    end
    busyIn = 1'b0;

    // R3 R4 R5 read sweep over the three pointer commands
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 8; k++) begin
        int a0, a1, a2, a3, pv;
        logic [7:0] pc;
        a0 = (k * 37) & 255; a1 = (k * 11 + 3) & 255; a2 = (255 - k * 5) & 255; a3 = k * 3;
        pc = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : 8'h50;
        pv = p;
        cmd(pc);
        chk("R3 pointer set", int'(areaPtr), pv);
        adr(8'(a0)); adr(8'(a1)); adr(8'(a2));
        chk("R5 no op before last address", lastEvt, 0);
        adr(8'(a3));
        chk("R5 read code", lastEvt, 1);
        chk("R5 read column", lastCol, a0);
        chk("R5 read row", lastRow, rowOf(a1, a2, a3));
        chk("R5 read area", lastArea, pv);
        chk("R4 pointer after read", int'(areaPtr), (pv == 1) ? 0 : pv);
      end
    end
    cmd(8'hFF);
    chk("R3 reset pointer", int'(areaPtr), 0);

    // R6 program, true and dummy
    for (int k = 0; k < 4; k++) begin
      int a0, a1, a2, a3;
      a0 = 200 - k; a1 = 17 * k; a2 = 90 + k; a3 = k + 1;
      cmd(8'h80); adr(8'(a0)); adr(8'(a1)); adr(8'(a2)); adr(8'(a3));
      chk("R6 no op before confirm", lastEvt, 0);
      cmd((k % 2 == 0) ? 8'h10 : 8'h11);
      chk("R6 program code", lastEvt, (k % 2 == 0) ? 2 : 3);
      chk("R6 program column", lastCol, a0);
      chk("R6 program row", lastRow, rowOf(a1, a2, a3));
    end

    // R7 copy-back
    for (int k = 0; k < 2; k++) begin
      cmd(8'h00); adr(8'h11); adr(8'h22); adr(8'h33); adr(8'h01);
      chk("R7 source read", lastEvt, 1);
      cmd(8'h8A);
      chk("R7 copy-back start", lastEvt, 0);
      adr(8'(5 + k)); adr(8'hA5); adr(8'h5A); adr(8'(k));
      cmd((k == 0) ? 8'h10 : 8'h11);
      chk("R7 copy-back code", lastEvt, (k == 0) ? 4 : 5);
      chk("R7 copy-back column", lastCol, 5 + k);
      chk("R7 copy-back row", lastRow, rowOf('hA5, 'h5A, k));
    end

    // R8 single and multi-plane erase
    cmd(8'h60); adr(8'h34); adr(8'h12); adr(8'h01); cmd(8'hD0);
    chk("R8 erase code", lastEvt, 6);
    chk("R8 erase row", lastRow, rowOf('h34, 'h12, 1));
    chk("R8 erase column", lastCol, 0);
    for (int n = 2; n <= 4; n++) begin
      for (int pl = 0; pl < n; pl++) begin
        cmd(8'h60);
        chk("R8 repeated erase setup", lastEvt, 0);
        adr(8'(pl + 10 * n)); adr(8'h77); adr(8'h00);
      end
      cmd(8'hD0);
      chk("R8 multi-plane erase code", lastEvt, 7);
      chk("R8 multi-plane erase row", lastRow, rowOf(n - 1 + 10 * n, 'h77, 0));
    end

    // R11 sequence errors
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h10);
    chk("R11 short program", lastEvt, 13);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04);
    chk("R11 extra erase address", lastEvt, 13);
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0);
    chk("R11 short erase", lastEvt, 13);
    cmd(8'h60); adr(8'h01); cmd(8'h60);
    chk("R11 short plane then repeat", lastEvt, 13);
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
    chk("R11 address after read", lastEvt, 13);
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
    chk("R11 fifth program address", lastEvt, 13);
    cmd(8'hFF); adr(8'h09);
    chk("R11 address while idle", lastEvt, 13);

    // R12 busy leaves sequence untouched
    cmd(8'h00); adr(8'h40); adr(8'h41);
    busyIn = 1'b1;
    adr(8'hEE); chk("R12 busy address", lastEvt, 14);
    cmd(8'h80); chk("R12 busy program", lastEvt, 14);
    cmd(8'h70); chk("R12 busy status", lastEvt, 8);
    busyIn = 1'b0;
    adr(8'h42); adr(8'h01);
    chk("R12 read resumes", lastEvt, 1);
    chk("R12 read row intact", lastRow, rowOf('h41, 'h42, 1));

    // R10 illegal drops sequence
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); cmd(8'h33);
    chk("R10 illegal byte", lastEvt, 12);
    cmd(8'h10);
    chk("R10 sequence dropped", lastEvt, 13);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule